// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is a serial test port in the style of IEEE 1149.1. A four-wire interface (test clock, mode select, serial data in, serial data out) plus an active-low test reset steers a sixteen-state controller. The controller moves bits through an 8-bit instruction register or through one of three data registers: a single-bit bypass stage, a 32-bit identification word, and a boundary chain of parameterised length placed across the core's pins.

The instruction register decodes five codes. The all-zeros code hands the output pins to the boundary chain. Code 8'h01 takes a snapshot of the pins while the core keeps its outputs. Code 8'h04 reads the identification word. The all-ones code and the reserved code 8'h53 select the one-bit bypass path, and so does every other code. A test controller on a board uses the port to identify the die, to check the wiring between chips and to shorten a scan chain through parts it does not need.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While trst_n is low at a rising edge of tck, the controller goes to Test-Logic-Reset and the active instruction becomes IDCODE (8'h04). The first data scan after reset therefore returns the identification word.
- R2: Five consecutive rising edges of tck with tms high bring the controller to Test-Logic-Reset from any state, and the active instruction becomes IDCODE.
- R3: In Capture-IR the instruction shift register loads 8'b00000001. An instruction scan shifts it out on tdo, least significant bit first.
- R4: Under IDCODE (8'h04) a data scan shifts out the 32-bit ID_VALUE, least significant bit first. The default ID_VALUE is 32'h100DE083: version 4'b0001 in bits 31:28, part field 16'h00DE in bits 27:12, maker field 11'b00001000001 in bits 11:1, and bit 0 set to 1.
- R5: Under BYPASS (8'hFF) the data path is one bit long. It captures 0, so the first bit out is 0, and each bit on tdi appears on tdo one tck cycle later.
- R6: The reserved code 8'h53 behaves exactly like BYPASS. pad_out keeps following core_out and pad_drive stays low.
- R7: Any code other than 8'h00, 8'h01, 8'h04, 8'h53 and 8'hFF selects the bypass path.
- R8: Under SAMPLE (8'h01), Capture-DR loads pin_in into the boundary chain, and bit 0 is the first bit out. pad_out equals core_out and pad_drive is low. Update-DR copies the shifted chain into the boundary update register.
- R9: Under EXTEST (8'h00), pad_drive is high and pad_out equals the boundary update register. The register can be preloaded under SAMPLE and rewritten by each EXTEST scan.
- R10: tdo and tdo_en change only on falling edges of tck. tdo_en is high only while the controller is in Shift-DR or Shift-IR.
- R11: A new instruction takes effect only on the falling edge of tck in Update-IR. During Shift-IR and Exit1-IR the old instruction still controls pad_drive and pad_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on tck |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial data into the selected register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | High while tdo carries data (shift states) |
| pin_in | input | BSR_LEN | Pin levels captured by the boundary chain |
| core_out | input | BSR_LEN | Functional output values from the core |
| pad_out | output | BSR_LEN | Values presented to the output pins |
| pad_drive | output | 1 | Boundary output enable, high under EXTEST |

## Verification
The hardest case to reach is an instruction change that is still pending. EXTEST must stay in force after the new code has been shifted in and the controller sits in Exit1-IR, and it must give way only at the falling edge in Update-IR. The bench builds that step by hand: it shifts a BYPASS code while EXTEST is active, stops in Exit1-IR, and looks at pad_drive before and after the Update-IR edge. A second hard case is a chain preloaded under SAMPLE. That value must appear on the pins at the moment EXTEST is loaded, with no data scan in between. Random runs mix undefined codes, random scan lengths and random pin levels with these directed steps.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, data path
// selection and the fixed instruction codes.
package jtag_tap_pkg;

    localparam int IR_W = 8;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUNDARY
    } dr_path_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h01;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h04;
    localparam logic [IR_W-1:0] OP_DEVTEST = 8'h53;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;

endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state test controller. Follows tms on each rising edge of tck.
// Assumes trst_n is sampled synchronously on tck (active low).
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state function of the standard controller graph
    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous test reset
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

endmodule

// File: rtl/jtag_ir_dec.sv
// Instruction shift register, active instruction latch and decoder.
// The active instruction changes only on falling tck in Update-IR. It
// falls back to IDCODE in Test-Logic-Reset or while trst_n is low.
module jtag_ir_dec
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_q,
    output dr_path_e        path,
    output logic            extest
);

    localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_sh;

    // Capture the fixed pattern, then shift toward tdo
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sh <= CAPTURE_PAT;
        else if (state == ST_CAP_IR) ir_sh <= CAPTURE_PAT;
        else if (state == ST_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Active instruction, changed on falling tck only
    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_TLR) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)    ir_q <= ir_sh;
    end

    assign ir_so = ir_sh[0];

    // Map the instruction code to a data path; unknown codes bypass
    always_comb begin
        extest = 1'b0;
        unique case (ir_q)
            OP_EXTEST: begin path = PATH_BOUNDARY; extest = 1'b1; end
            OP_SAMPLE: path = PATH_BOUNDARY;
            OP_IDCODE: path = PATH_IDENT;
            default:   path = PATH_BYPASS;
        endcase
    end

endmodule

// File: rtl/jtag_dr_chain.sv
// Data registers: one-bit bypass, identification word and boundary chain
// with its update latch. Only the selected register captures and shifts.
module jtag_dr_chain
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h100DE083
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_path_e           path,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_so,
    output logic [BSR_LEN-1:0] bsr_upd
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;

    // Bypass stage: captures zero, passes tdi one cycle later
    always_ff @(posedge tck) begin
        if (!trst_n) byp_q <= 1'b0;
        else if (path == PATH_BYPASS) begin
            if (state == ST_CAP_DR)      byp_q <= 1'b0;
            else if (state == ST_SHF_DR) byp_q <= tdi;
        end
    end

    // Identification word: load the constant, shift LSB first
    always_ff @(posedge tck) begin
        if (!trst_n) id_sh <= ID_VALUE;
        else if (path == PATH_IDENT) begin
            if (state == ST_CAP_DR)      id_sh <= ID_VALUE;
            else if (state == ST_SHF_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    // Boundary chain: snapshot the pins, shift with bit 0 nearest tdo
    always_ff @(posedge tck) begin
        if (!trst_n) bsr_sh <= '0;
        else if (path == PATH_BOUNDARY) begin
            if (state == ST_CAP_DR)      bsr_sh <= pin_in;
            else if (state == ST_SHF_DR) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        end
    end

    // Boundary update latch, written on falling tck in Update-DR
    always_ff @(negedge tck) begin
        if (!trst_n) bsr_upd <= '0;
        else if (state == ST_UPD_DR && path == PATH_BOUNDARY) bsr_upd <= bsr_sh;
    end

    // Serial output of the selected register
    always_comb begin
        unique case (path)
            PATH_IDENT:    dr_so = id_sh[0];
            PATH_BOUNDARY: dr_so = bsr_sh[0];
            default:       dr_so = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_ctrl.sv
// Top of the test access port. Ties together the controller, the
// instruction decoder and the data registers. Drives tdo on falling tck
// and hands the pins to the boundary latch under EXTEST.
// Assumes tck is the only clock and trst_n is sampled on it.
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h100DE083
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    input  logic [BSR_LEN-1:0] pin_in,
    input  logic [BSR_LEN-1:0] core_out,
    output logic [BSR_LEN-1:0] pad_out,
    output logic               pad_drive
);

    tap_state_e         state;
    logic [IR_W-1:0]    ir_q;
    dr_path_e           path;
    logic               extest;
    logic               ir_so;
    logic               dr_so;
    logic [BSR_LEN-1:0] bsr_upd;
    logic               sel_bypass;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    jtag_ir_dec u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir_so  (ir_so),
        .ir_q   (ir_q),
        .path   (path),
        .extest (extest)
    );

    jtag_dr_chain #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .path    (path),
        .pin_in  (pin_in),
        .dr_so   (dr_so),
        .bsr_upd (bsr_upd)
    );

    assign sel_bypass = (path == PATH_BYPASS);

    // Serial output stage, updated half a cycle after the shift edge
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SHF_DR) || (state == ST_SHF_IR);
            tdo    <= (state == ST_SHF_IR) ? ir_so : dr_so;
        end
    end

    // Pin multiplexer: the core owns the pins except under EXTEST
    assign pad_out   = extest ? bsr_upd : core_out;
    assign pad_drive = extest;

endmodule

// File: rtl/jtag_tap_checker.sv
// Temporal checks on the test access port, bound into every instance of
// the top module. Observes ports plus the controller state and the
// active instruction.
module jtag_tap_checker
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdi,
    input logic            tdo,
    input logic            tdo_en,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic            sel_bypass
);

    logic [2:0] tms_run;

    // Count consecutive rising edges with tms high, saturating at five
    always_ff @(posedge tck) begin
        if (!trst_n)              tms_run <= '0;
        else if (!tms)            tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    AST_IR_RESET_VALUE: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(trst_n) |-> (ir_q == OP_IDCODE)); // R1

    AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_TLR)); // R2

    AST_BYPASS_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == ST_SHF_DR && state == ST_SHF_DR && sel_bypass) |-> (tdo == $past(tdi))); // R5

    AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SHF_DR || state == ST_SHF_IR)); // R10

    AST_IR_HOLDS: assert property (@(negedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q)); // R11

endmodule

bind jtag_tap_ctrl jtag_tap_checker u_jtag_tap_checker (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .tdi        (tdi),
    .tdo        (tdo),
    .tdo_en     (tdo_en),
    .state      (state),
    .ir_q       (ir_q),
    .sel_bypass (sel_bypass)
);

// File: tb/test_jtag_tap_ctrl.sv
// Bench for the test access port: directed corner cases plus seeded
// random scans, each compared with values computed here.
module test_jtag_tap_ctrl;

    localparam int          N      = 8;
    localparam logic [31:0] ID     = 32'h100DE083;
    localparam time         PERIOD = 8ns;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         tdo, tdo_en;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] core_out = '0;
    logic [N-1:0] pad_out;
    logic         pad_drive;

    int n_chk = 0;
    int n_fail = 0;
    logic last_en;
    logic en_all;

    always #(PERIOD/2) tck = ~tck;

    jtag_tap_ctrl #(.BSR_LEN(N), .ID_VALUE(ID)) i_jtag_tap_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pin_in(pin_in), .core_out(core_out), .pad_out(pad_out), .pad_drive(pad_drive)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One tck cycle: drive after the falling edge, sample tdo before the rise
    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #1;
        o = tdo;
        last_en = tdo_en;
        @(posedge tck);
    endtask

    task automatic step(input logic m);
        logic o;
        tick(m, 1'b0, o);
    endtask

    // From Run-Test/Idle: full data scan of n bits, back to Run-Test/Idle
    task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
        logic o;
        dout = '0;
        en_all = 1'b1;
        step(1); step(0); step(0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
            en_all &= last_en;
        end
        step(1); step(0);
    endtask

    // From Run-Test/Idle: load an instruction, return the captured bits
    task automatic scan_ir(input logic [7:0] code, output logic [7:0] cap);
        logic o;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 8; i++) begin
            tick(i == 7, code[i], o);
            cap[i] = o;
        end
        step(1); step(0);
    endtask

    function automatic logic [63:0] exp_bypass(input logic [63:0] din, input int n);
        logic [63:0] r = {din[62:0], 1'b0};
        return r & ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [63:0] mask(input logic [63:0] v, input int n);
        return v & ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [7:0] undefined_code();
        logic [7:0] c;
        do c = 8'($urandom); while (c == 8'h00 || c == 8'h01 || c == 8'h04 ||
                                    c == 8'h53 || c == 8'hFF);
        return c;
    endfunction

    task automatic bypass_run(input string req);
        logic [63:0] din, dout;
        int n;
        n = 2 + int'($urandom % 40);
        din = {$urandom, $urandom};
        scan_dr(din, n, dout);
        check(req, "bypass path", dout, exp_bypass(din, n));
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [63:0] dout;
        logic [7:0]  cap;
        logic [N-1:0] pre, nv;
        logic o;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(posedge tck);
        #1;
        check("R10", "tdo_en in reset", {63'd0, tdo_en}, 64'd0);
        check("R8", "pad_drive after reset", {63'd0, pad_drive}, 64'd0);
        trst_n = 1'b1;
        step(0);
        check("R10", "tdo_en in idle", {63'd0, tdo_en}, 64'd0);
        scan_dr(64'd0, 32, dout);
        check("R1", "ID after reset", dout, {32'd0, ID});
        check("R10", "tdo_en during shift", {63'd0, en_all}, 64'd1);
        step(0);
        check("R10", "tdo_en back in idle", {63'd0, last_en}, 64'd0);

        // R3 and R4: capture pattern, explicit IDCODE load
        scan_ir(8'h04, cap);
        check("R3", "IR capture pattern", {56'd0, cap}, 64'h01);
        scan_dr({32'd0, 32'hFFFF_FFFF}, 32, dout);
        check("R4", "ID fields", dout, 64'h100DE083);

        // R5: bypass delay
        scan_ir(8'hFF, cap);
        bypass_run("R5");

        // R6: reserved code acts as bypass and leaves pins alone
        core_out = 8'hA5;
        scan_ir(8'h53, cap);
        bypass_run("R6");
        check("R6", "pad_out follows core", {56'd0, pad_out}, 64'hA5);
        check("R6", "pad_drive low", {63'd0, pad_drive}, 64'd0);

        // R7: undefined code
        scan_ir(undefined_code(), cap);
        bypass_run("R7");

        // R8: sample snapshot and preload
        pin_in = 8'h3C;
        core_out = 8'h5A;
        pre = 8'hC3;
        scan_ir(8'h01, cap);
        scan_dr({56'd0, pre}, N, dout);
        check("R8", "sample capture", dout, 64'h3C);
        check("R8", "pad_out during sample", {56'd0, pad_out}, 64'h5A);
        check("R8", "pad_drive during sample", {63'd0, pad_drive}, 64'd0);

        // R9: extest drives the preloaded value, then a new one
        scan_ir(8'h00, cap);
        check("R9", "pad_drive under extest", {63'd0, pad_drive}, 64'd1);
        check("R9", "preload on pins", {56'd0, pad_out}, {56'd0, pre});
        nv = 8'h96;
        pin_in = 8'h0F;
        scan_dr({56'd0, nv}, N, dout);
        check("R9", "extest capture", dout, 64'h0F);
        check("R9", "new value on pins", {56'd0, pad_out}, 64'h96);

        // R11: instruction change waits for Update-IR
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 8; i++) tick(i == 7, 1'b1, o);
        check("R11", "extest still active in Exit1-IR", {63'd0, pad_drive}, 64'd1);
        step(1);
        check("R11", "extest held until falling edge", {63'd0, pad_drive}, 64'd1);
        @(negedge tck);
        #1;
        check("R11", "bypass after Update-IR", {63'd0, pad_drive}, 64'd0);
        step(0);

        // R2: five tms high from Shift-DR
        step(1); step(0); step(0);
        for (int i = 0; i < 5; i++) step(1);
        step(0);
        scan_dr(64'd0, 32, dout);
        check("R2", "ID after five tms", dout, {32'd0, ID});

        // R1: trst mid-operation
        scan_ir(8'hFF, cap);
        step(1); step(0);
        trst_n = 1'b0;
        step(0);
        trst_n = 1'b1;
        step(0);
        scan_dr(64'd0, 32, dout);
        check("R1", "ID after trst", dout, {32'd0, ID});

        // Random mix
        for (int k = 0; k < 24; k++) begin
            case ($urandom % 4)
                0: begin scan_ir(8'hFF, cap); bypass_run("R5"); end
                1: begin scan_ir(undefined_code(), cap); bypass_run("R7"); end
                2: begin
                    pin_in = N'($urandom);
                    core_out = N'($urandom);
                    scan_ir(8'h01, cap);
                    check("R3", "IR capture pattern", {56'd0, cap}, 64'h01);
                    scan_dr({$urandom, $urandom}, N, dout);
                    check("R8", "sample capture", dout, mask({56'd0, pin_in}, N));
                    check("R8", "pad_out during sample", {56'd0, pad_out}, {56'd0, core_out});
                end
                default: begin
                    scan_ir(8'h04, cap);
                    scan_dr({$urandom, $urandom}, 32, dout);
                    check("R4", "ID value", dout, {32'd0, ID});
                end
            endcase
        end

        summary();
    end

endmodule